// File: doc/BRIEF.md
# Cross-Domain Register Transfer Busy Tracker

This block links a bus clock domain to an oscillator-control clock domain for six control and readback registers: a fractional divider, a loop multiplier, a loop difference readback, a tune value, a secondary control register and a single enable bit. A bus access to one of these registers starts a transfer across the clock boundary, and the register's busy flag stays set until that transfer has finished. The flags are gathered into a 32-bit read-only status word. Software polls the word to learn when a new value has reached the oscillator side, or when a value fetched from the oscillator side can be read.

Each register has its own trigger. The divider, multiplier, secondary-control and enable registers move data only toward the oscillator, so only bus writes start their transfers. The difference register moves data only toward the bus, so only bus reads start its transfer. The tune register does both. Each transfer uses a toggle request and a toggle acknowledge, and each of these passes through a two-flop synchronizer. The data rides in registers that hold still while the toggles travel.

Top module: `regsync_busy_tracker`

## Requirements
- R1: After reset the status word, the read data and every oscillator-side output are zero.
- R2: In the status word, bit 1 is the enable flag, bit 2 the secondary control, bit 3 the tune, bit 4 the difference, bit 5 the multiplier and bit 6 the divider. All other bits are zero. Select code 7 reads the status word on the low DW bits of the read data. Select code 6 reads zero. Writes to either code have no effect.
- R3: An accepted access raises its register's flag on the first bus clock edge after it is presented. A flag never rises without an access.
- R4: Select codes 0 (enable), 1 (secondary control), 4 (multiplier) and 5 (divider) start a transfer only on a bus write. A read of these codes leaves every flag unchanged.
- R5: Select code 3 (difference) starts a transfer only on a bus read. A write to it is ignored.
- R6: Select code 2 (tune) starts a transfer on a read and also on a write.
- R7: A flag clears on the second bus edge after the acknowledge toggles. The acknowledge toggles on the third oscillator edge after the request toggles.
- R8: A written value appears on its oscillator output at the oscillator edge that toggles the acknowledge. The enable output is bit 0 of the value written to code 0.
- R9: Any access to a register whose flag is set is ignored: no new transfer starts and the value in flight is kept.
- R10: A read transfer samples the oscillator input at the acknowledge edge. Codes 3 and 2 return that sample from the bus edge that clears the flag until the next read of that code completes.
- R11: Read data at codes 0, 1, 4 and 5 is the last write that was accepted for that code.
- R12: If a read and a write of code 2 occur in the same cycle, the write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus domain clock |
| clk_osc | input | 1 | Oscillator-control domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_sel | input | 3 | Register select code |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the selected code |
| status_word | output | 32 | Busy flags |
| osc_diff_in | input | DW | Difference value in the oscillator domain |
| osc_tune_in | input | DW | Tune value in the oscillator domain |
| osc_frac | output | DW | Divider value applied in the oscillator domain |
| osc_mul | output | DW | Multiplier value applied in the oscillator domain |
| osc_tune | output | DW | Tune value applied in the oscillator domain |
| osc_ctrlb | output | DW | Secondary control value applied in the oscillator domain |
| osc_enable | output | 1 | Enable bit applied in the oscillator domain |

## Verification
The oscillator clock runs at half the bus rate, and its edges line up with every second bus edge. This fixes the handshake latency, so the model can predict it exactly. Directed phases send reads to the write-only registers and writes to the read-only one, which separates the per-register triggers. Back-to-back accesses to a busy register show whether held-off accesses corrupt the value in flight. Changing the oscillator inputs during a read shows the exact edge at which the sample is taken. A simultaneous read and write of the tune register checks the precedence rule. A long pseudo-random stretch overlaps transfers on all six registers, which catches cross-talk between flags.

// File: rtl/regsync_busy_pkg.sv
package regsync_busy_pkg;
  localparam int NCH = 6;
  localparam int STAT_W = 32;
  localparam int FLAG_LSB = 1;

  localparam int CH_ENA   = 0;
  localparam int CH_CTRLB = 1;
  localparam int CH_TUNE  = 2;
  localparam int CH_DIFF  = 3;
  localparam int CH_MUL   = 4;
  localparam int CH_FRAC  = 5;

  localparam logic [NCH-1:0] WR_MASK = 6'b110111;
  localparam logic [NCH-1:0] RD_MASK = 6'b001100;

  localparam logic [2:0] SEL_STATUS = 3'd7;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/cdc_sync2.sv
module cdc_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/chan_xfer.sv
module chan_xfer #(
  parameter int DW     = 16,
  parameter bit CAN_WR = 1'b1,
  parameter bit CAN_RD = 1'b0
) (
  input  logic          clk_b,
  input  logic          rst_bn,
  input  logic          clk_o,
  input  logic          rst_on,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic [DW-1:0] bus_val,
  input  logic [DW-1:0] osc_in,
  output logic [DW-1:0] osc_q
);
  // bus-domain state
  logic          req_q, req_d;
  logic          dir_q, dir_d;
  logic          ack_m_q, ack_s_q;
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] shadow_q, shadow_d;
  logic          start_wr, start_rd, land;
  // oscillator-domain state
  logic          req_s;
  logic          ack_q, ack_d;
  logic          pend;
  logic [DW-1:0] oreg_q, oreg_d;
  logic [DW-1:0] cap_q, cap_d;

  assign busy     = req_q ^ ack_s_q;
  assign start_wr = CAN_WR && wr && !busy;
  assign start_rd = CAN_RD && rd && !(CAN_WR && wr) && !busy;
  assign land     = ack_m_q ^ ack_s_q;

  always_comb begin
    req_d    = req_q ^ (start_wr | start_rd);
    dir_d    = (start_wr | start_rd) ? start_rd : dir_q;
    hold_d   = start_wr ? wdata : hold_q;
    shadow_d = (land && dir_q) ? cap_q : shadow_q;
  end

  always_ff @(posedge clk_b or negedge rst_bn) begin
    if (!rst_bn) begin
      req_q    <= 1'b0;
      dir_q    <= 1'b0;
      ack_m_q  <= 1'b0;
      ack_s_q  <= 1'b0;
      hold_q   <= '0;
      shadow_q <= '0;
    end else begin
      req_q    <= req_d;
      dir_q    <= dir_d;
      ack_m_q  <= ack_q;
      ack_s_q  <= ack_m_q;
      hold_q   <= hold_d;
      shadow_q <= shadow_d;
    end
  end

  cdc_sync2 u_req_sync (
    .clk   (clk_o),
    .rst_n (rst_on),
    .d     (req_q),
    .q     (req_s)
  );

  assign pend = req_s ^ ack_q;

  always_comb begin
    ack_d  = ack_q ^ pend;
    oreg_d = (pend && !dir_q) ? hold_q : oreg_q;
    cap_d  = (pend && dir_q) ? osc_in : cap_q;
  end

  always_ff @(posedge clk_o or negedge rst_on) begin
    if (!rst_on) begin
      ack_q  <= 1'b0;
      oreg_q <= '0;
      cap_q  <= '0;
    end else begin
      ack_q  <= ack_d;
      oreg_q <= oreg_d;
      cap_q  <= cap_d;
    end
  end

  generate
    if (CAN_RD) begin : g_rd_view
      assign bus_val = shadow_q;
    end else begin : g_wr_view
      assign bus_val = hold_q;
    end
    if (CAN_WR) begin : g_drive
      assign osc_q = oreg_q;
    end else begin : g_nodrive
      assign osc_q = '0;
    end
  endgenerate

  // R3: an accepted access shows as busy on the next bus edge
  a_r3_flag_on_accept: assert property (@(posedge clk_b) disable iff (!rst_bn)
    (start_wr || start_rd) |=> busy);
  // R3: a flag only rises after an access strobe
  a_r3_rise_needs_access: assert property (@(posedge clk_b) disable iff (!rst_bn)
    $rose(busy) |-> $past(wr || rd));
  // R9: the outgoing value is frozen while in flight
  a_r9_hold_frozen: assert property (@(posedge clk_b) disable iff (!rst_bn)
    busy |=> $stable(hold_q));
  // R10: readback only changes on the edge that ends a transfer
  a_r10_shadow_frozen: assert property (@(posedge clk_b) disable iff (!rst_bn)
    !busy |=> $stable(shadow_q));
  // R8: oscillator register only moves when a request is being acknowledged
  a_r8_oreg_on_ack: assert property (@(posedge clk_o) disable iff (!rst_on)
    !$stable(oreg_q) |-> $past(pend));
endmodule

// File: rtl/regsync_busy_tracker.sv
module regsync_busy_tracker
  import regsync_busy_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_bus,
  input  logic          clk_osc,
  input  logic          rst_n,
  input  logic [2:0]    bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [31:0]   status_word,
  input  logic [DW-1:0] osc_diff_in,
  input  logic [DW-1:0] osc_tune_in,
  output logic [DW-1:0] osc_frac,
  output logic [DW-1:0] osc_mul,
  output logic [DW-1:0] osc_tune,
  output logic [DW-1:0] osc_ctrlb,
  output logic          osc_enable
);
  localparam int PAD_W = STAT_W - NCH - FLAG_LSB;

  logic            rst_bn, rst_on;
  logic [NCH-1:0]  hit;
  logic [NCH-1:0]  busy;
  logic [DW-1:0]   bus_val [NCH];
  logic [DW-1:0]   osc_in_a [NCH];
  logic [DW-1:0]   osc_q_a [NCH];
  logic            unused_osc;

  rst_sync u_rst_bus (.clk(clk_bus), .arst_n(rst_n), .srst_n(rst_bn));
  rst_sync u_rst_osc (.clk(clk_osc), .arst_n(rst_n), .srst_n(rst_on));

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      hit[i]      = (bus_sel == 3'(i));
      osc_in_a[i] = '0;
    end
    osc_in_a[CH_TUNE] = osc_tune_in;
    osc_in_a[CH_DIFF] = osc_diff_in;
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      chan_xfer #(
        .DW     (DW),
        .CAN_WR (WR_MASK[g]),
        .CAN_RD (RD_MASK[g])
      ) u_ch (
        .clk_b   (clk_bus),
        .rst_bn  (rst_bn),
        .clk_o   (clk_osc),
        .rst_on  (rst_on),
        .wr      (bus_wr & hit[g]),
        .rd      (bus_rd & hit[g]),
        .wdata   (bus_wdata),
        .busy    (busy[g]),
        .bus_val (bus_val[g]),
        .osc_in  (osc_in_a[g]),
        .osc_q   (osc_q_a[g])
      );
    end
  endgenerate

  assign status_word = {{PAD_W{1'b0}}, busy, {FLAG_LSB{1'b0}}};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel == SEL_STATUS) begin
      bus_rdata = status_word[DW-1:0];
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (hit[i]) bus_rdata = bus_val[i];
      end
    end
  end

  assign osc_frac   = osc_q_a[CH_FRAC];
  assign osc_mul    = osc_q_a[CH_MUL];
  assign osc_tune   = osc_q_a[CH_TUNE];
  assign osc_ctrlb  = osc_q_a[CH_CTRLB];
  assign osc_enable = osc_q_a[CH_ENA][0];
  assign unused_osc = ^{osc_q_a[CH_DIFF], osc_q_a[CH_ENA][DW-1:1]};
endmodule

// File: tb/regsync_busy_tracker_tb.sv
`timescale 1ns/1ps
module regsync_busy_tracker_tb;
  import regsync_busy_pkg::*;
  localparam int DW = 16;

  bit clk_bus, clk_osc;
  logic rst_n;
  logic [2:0] bus_sel;
  logic bus_wr, bus_rd;
  logic [DW-1:0] bus_wdata, osc_diff_in, osc_tune_in;
  logic [DW-1:0] bus_rdata, osc_frac, osc_mul, osc_tune, osc_ctrlb;
  logic [31:0] status_word;
  logic osc_enable;

  regsync_busy_tracker #(.DW(DW)) u_dut (
    .clk_bus(clk_bus), .clk_osc(clk_osc), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_word(status_word),
    .osc_diff_in(osc_diff_in), .osc_tune_in(osc_tune_in),
    .osc_frac(osc_frac), .osc_mul(osc_mul), .osc_tune(osc_tune),
    .osc_ctrlb(osc_ctrlb), .osc_enable(osc_enable));

  // 200 MHz bus clock; oscillator clock at half rate, rising with every odd bus edge
  initial forever #2.5 clk_bus = ~clk_bus;
  initial begin
    #2.5;
    forever begin
      clk_osc = ~clk_osc;
      #5;
    end
  end

  bit            m_busy [NCH];
  int            m_oscl [NCH];
  int            m_busl [NCH];
  bit            m_dir [NCH];
  logic [DW-1:0] m_hold [NCH];
  logic [DW-1:0] m_oreg [NCH];
  logic [DW-1:0] m_cap [NCH];
  logic [DW-1:0] m_shadow [NCH];
  int    ecount = 0;
  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 0;

  function automatic logic [DW-1:0] osc_src(int ch);
    if (ch == CH_TUNE) return osc_tune_in;
    if (ch == CH_DIFF) return osc_diff_in;
    return '0;
  endfunction

  // behavioural reference: countdown of oscillator edges, then bus edges
  always @(posedge clk_bus) begin
    bit osce;
    bit pre [NCH];
    ecount++;
    osce = (ecount % 2) == 1;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_busy[c] = 0; m_oscl[c] = 0; m_busl[c] = 0; m_dir[c] = 0;
        m_hold[c] = '0; m_oreg[c] = '0; m_cap[c] = '0; m_shadow[c] = '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit wr_ok, rd_ok;
        pre[c] = m_busy[c];
        if (m_busl[c] > 0) begin
          m_busl[c]--;
          if (m_busl[c] == 0) begin
            m_busy[c] = 0;
            if (m_dir[c]) m_shadow[c] = m_cap[c];
          end
        end
        if (m_oscl[c] > 0 && osce) begin
          m_oscl[c]--;
          if (m_oscl[c] == 0) begin
            m_busl[c] = 2;
            if (m_dir[c]) m_cap[c] = osc_src(c);
            else m_oreg[c] = m_hold[c];
          end
        end
        wr_ok = bus_wr && (bus_sel == 3'(c)) && WR_MASK[c];
        rd_ok = bus_rd && (bus_sel == 3'(c)) && RD_MASK[c] && !wr_ok;
        if (!pre[c] && (wr_ok || rd_ok)) begin
          m_busy[c] = 1;
          m_oscl[c] = 3;
          m_dir[c]  = rd_ok;
          if (wr_ok) m_hold[c] = bus_wdata;
        end
      end
    end
  end

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    for (int c = 0; c < NCH; c++) s[c+1] = m_busy[c];
    return s;
  endfunction

  function automatic logic [DW-1:0] exp_rdata();
    logic [31:0] s = exp_status();
    if (bus_sel == 3'd7) return s[DW-1:0];
    if (bus_sel == 3'd6) return '0;
    if (RD_MASK[bus_sel]) return m_shadow[bus_sel];
    return m_hold[bus_sel];
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_bus) begin
    #1;
    if (!done) begin
      chk("status", status_word, exp_status());
      chk("rdata", 32'(bus_rdata), 32'(exp_rdata()));
      chk("osc_frac", 32'(osc_frac), 32'(m_oreg[CH_FRAC]));
      chk("osc_mul", 32'(osc_mul), 32'(m_oreg[CH_MUL]));
      chk("osc_tune", 32'(osc_tune), 32'(m_oreg[CH_TUNE]));
      chk("osc_ctrlb", 32'(osc_ctrlb), 32'(m_oreg[CH_CTRLB]));
      chk("osc_enable", 32'(osc_enable), 32'(m_oreg[CH_ENA][0]));
    end
  end

  task automatic cyc(logic [2:0] s, logic w, logic r, logic [DW-1:0] d);
    @(negedge clk_bus);
    bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(3'd7, 1'b0, 1'b0, '0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; bus_sel = 3'd7; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    osc_diff_in = '0; osc_tune_in = '0;
    repeat (4) @(negedge clk_bus);
    rst_n = 1;
    cur_req = "R1"; idle(6);

    cur_req = "R4"; // reads of write-only codes start nothing
    foreach (WR_MASK[c]) if (!RD_MASK[c]) begin cyc(3'(c), 0, 1, '0); idle(1); end
    idle(3);

    cur_req = "R8"; // writes reach oscillator outputs at the acknowledge edge
    cyc(3'd5, 1, 0, 16'hA5A5); cyc(3'd4, 1, 0, 16'h0F0F);
    cyc(3'd1, 1, 0, 16'h3C3C); cyc(3'd0, 1, 0, 16'h0001);
    idle(20);

    cur_req = "R11"; // read data of write-only codes is the last accepted write
    cyc(3'd0, 0, 1, '0); cyc(3'd1, 0, 1, '0); cyc(3'd4, 0, 1, '0); cyc(3'd5, 0, 1, '0);
    idle(2);

    cur_req = "R3"; // single write: flag rises one edge later
    cyc(3'd4, 1, 0, 16'h1111); idle(15);

    cur_req = "R9"; // accesses while busy are dropped
    cyc(3'd5, 1, 0, 16'h2222); cyc(3'd5, 1, 0, 16'h3333); cyc(3'd5, 1, 0, 16'h4444);
    idle(20);

    cur_req = "R5"; // difference: writes ignored, reads fetch
    osc_diff_in = 16'h1234;
    cyc(3'd3, 1, 0, 16'hFFFF); idle(10);
    cyc(3'd3, 0, 1, '0); cyc(3'd3, 0, 0, '0); cyc(3'd3, 0, 0, '0);
    osc_diff_in = 16'h5678;
    idle(20);

    cur_req = "R10"; // readback value appears as the flag clears
    osc_diff_in = 16'hBEEF;
    cyc(3'd3, 0, 1, '0);
    repeat (14) cyc(3'd3, 0, 0, '0);
    osc_diff_in = 16'hCAFE;
    repeat (4) cyc(3'd3, 0, 0, '0);
    cyc(3'd3, 0, 1, '0);
    repeat (14) cyc(3'd3, 0, 0, '0);

    cur_req = "R6"; // tune: both directions
    osc_tune_in = 16'h0A0A;
    cyc(3'd2, 0, 1, '0);
    repeat (14) cyc(3'd2, 0, 0, '0);
    cyc(3'd2, 1, 0, 16'h7777);
    idle(14);

    cur_req = "R12"; // simultaneous read and write of tune: write wins
    osc_tune_in = 16'h0B0B;
    cyc(3'd2, 1, 1, 16'h6666);
    repeat (14) cyc(3'd2, 0, 0, '0);

    cur_req = "R2"; // status layout with all flags up; writes to codes 6 and 7 ignored
    cyc(3'd7, 1, 0, 16'hFFFF); cyc(3'd6, 1, 1, 16'hFFFF);
    cyc(3'd0, 1, 0, 16'h0000); cyc(3'd1, 1, 0, 16'h1357); cyc(3'd2, 1, 0, 16'h2468);
    cyc(3'd3, 0, 1, '0); cyc(3'd4, 1, 0, 16'h9ABC); cyc(3'd5, 1, 0, 16'hDEF0);
    idle(20);

    cur_req = "R7"; // overlapping random traffic
    for (int i = 0; i < 600; i++) begin
      int u = $urandom;
      if (u[12:10] == 3'd0) osc_diff_in = 16'($urandom);
      if (u[15:13] == 3'd0) osc_tune_in = 16'($urandom);
      cyc(3'(u[2:0]), u[5:3] == 3'd0, u[8:6] == 3'd0, 16'($urandom));
    end
    idle(20);
    finish_run();
  end
endmodule